// File: doc/BRIEF.md
# Timer Count-Enable Source Selector and Prescaler

This block decides when a timer counter may advance. It runs entirely on the bus clock. A two-bit source field picks one of four sources: nothing (the timer stands still), every bus cycle, a slow fixed-rate clock, or an external clock pin. The two slow sources are level signals from outside the bus domain. Each one passes through a synchronizer chain, and an edge detector then turns each of its edges into a single bus-cycle tick.

The selected tick stream feeds a power-of-two prescaler. A three-bit divide field sets the ratio, from 1 up to 128. The prescaler sits after synchronization and selection, so the chosen ratio applies to whichever source is active. The result is the `count_en` strobe, which lasts one bus cycle. A change to either field, or choosing the "none" source, restarts the prescaler from zero. The first strobe after a change therefore comes a full divide period later.

The external clock must toggle no faster than a quarter of the bus clock rate. At that rate each of its rising edges is seen exactly once.

Top module: `tmr_clk_prescale`

## Requirements
- R1: With source code 00 (none), `count_en` stays low whatever the fixed and external clock inputs do.
- R2: With source code 01 (bus) and divide code 000, `count_en` is high on every bus cycle once the settings have been steady for one cycle.
- R3: Divide code k (000 to 111) gives exactly one `count_en` pulse per 2^k ticks of the selected source. With the bus source, that is 256 >> k pulses in any 256 cycles that follow a settings change.
- R4: In the cycle in which `src_sel` or `div_sel` first shows a new value, `count_en` is low and the prescaler restarts from zero. With the bus source, the first pulse then falls 2^k cycles after that cycle.
- R5: With source code 11 (external), each rising edge of `ext_clk` counts as exactly one source tick, and each resulting pulse lasts one cycle. Falling edges count for nothing. This holds for pin rates up to a quarter of the bus rate.
- R6: With source code 10 (fixed), each rising edge of `fix_clk` counts as exactly one source tick.
- R7: Only the selected source advances the prescaler. Activity on the unselected slow input produces no pulses.
- R8: A pin edge reaches `count_en` through two synchronizer flops and an edge register. With divide code 000, the pulse appears in the second bus cycle after the first clock edge that samples the new pin level.
- R9: While `rst_n` is low, `count_en` is low. After release, the prescaler starts from zero, so with the bus source and divide code 011 the first pulse comes in the eighth cycle after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source code: 00 none, 01 bus, 10 fixed clock, 11 external pin |
| div_sel | input | PS_W (3) | Divide code k; the divide ratio is 2^k |
| fix_clk | input | 1 | Slow fixed-rate clock level, asynchronous to the bus clock |
| ext_clk | input | 1 | External clock pin level, at most a quarter of the bus rate |
| count_en | output | 1 | One-cycle enable strobe for the timer counter |

## Verification
The bound checker watches four things on every cycle:
- the none source stays silent;
- bus-rate operation at divide-by-1 is continuous;
- the change cycle is blanked;
- pulses never run back to back at divide ratios of two or more, or from the external source.

The actual pulse counts per divide code, the position of the first pulse after a change or reset, and the mapping of pin edges to ticks can only be shown by the bench. This includes the quarter-rate limit, the rejection of falling edges and the isolation of the unselected input. The bench shows them by counting strobes over fixed windows while it drives the pins.

// File: rtl/tcp_pkg.sv
`timescale 1ns/1ps
package tcp_pkg;
   typedef enum logic [1:0] {
      SRC_OFF = 2'b00,
      SRC_BUS = 2'b01,
      SRC_FIX = 2'b10,
      SRC_EXT = 2'b11
   } src_e;
endpackage

// File: rtl/tcp_edge_sync.sv
`timescale 1ns/1ps
// Synchronizer chain followed by a single-edge detector.
module tcp_edge_sync #(
   parameter int STAGES = 2,
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("tcp_edge_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= din;
   end

   for (genvar g = 1; g <= LAST; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= 1'b0;
         else        chain[g] <= chain[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[LAST];
   end

   if (RISING) begin : g_rise
      assign pulse = chain[LAST] & ~prev_q;
   end else begin : g_fall
      assign pulse = ~chain[LAST] & prev_q;
   end
endmodule

// File: rtl/tcp_src_mux.sv
`timescale 1ns/1ps
// Picks the tick stream that feeds the prescaler.
module tcp_src_mux
   import tcp_pkg::*;
(
   input  src_e sel,
   input  logic fix_tick,
   input  logic ext_tick,
   output logic tick
);
   always_comb begin
      unique case (sel)
         SRC_OFF: tick = 1'b0;
         SRC_BUS: tick = 1'b1;
         SRC_FIX: tick = fix_tick;
         SRC_EXT: tick = ext_tick;
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/tcp_prescaler.sv
`timescale 1ns/1ps
// Free-running binary prescaler; fires when the low k bits wrap.
module tcp_prescaler #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            tick,
   input  logic [PS_W-1:0] div_sel,
   output logic            fire
);
   localparam int CNT_W = (1 << PS_W) - 1;

   if (PS_W < 1 || PS_W > 5) begin : g_bad_width
      $error("tcp_prescaler: PS_W must lie in 1..5");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] low_mask;
   logic             at_wrap;

   assign low_mask = ~({CNT_W{1'b1}} << div_sel);
   assign at_wrap  = (cnt_q & low_mask) == low_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + 1'b1;
   end

   assign fire = tick & ~restart & at_wrap;
endmodule

// File: rtl/tmr_clk_prescale.sv
`timescale 1ns/1ps
// Timer count-enable generator: source select, sync, edge detect, prescale.
module tmr_clk_prescale
   import tcp_pkg::*;
#(
   parameter int PS_W        = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_RISE    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      src_sel,
   input  logic [PS_W-1:0] div_sel,
   input  logic            fix_clk,
   input  logic            ext_clk,
   output logic            count_en
);
   src_e            sel_now;
   src_e            sel_q;
   logic [PS_W-1:0] div_q;
   logic            restart;
   logic            fix_tick;
   logic            ext_tick;
   logic            src_tick;

   assign sel_now = src_e'(src_sel);

   // Registered copy of the settings; a mismatch marks a change cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SRC_OFF;
         div_q <= '0;
      end else begin
         sel_q <= sel_now;
         div_q <= div_sel;
      end
   end

   assign restart = (sel_now != sel_q) | (div_sel != div_q) | (sel_now == SRC_OFF);

   tcp_edge_sync #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_fix_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (fix_clk),
      .pulse (fix_tick)
   );

   tcp_edge_sync #(.STAGES(SYNC_STAGES), .RISING(EXT_RISE)) u_ext_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_clk),
      .pulse (ext_tick)
   );

   tcp_src_mux u_mux (
      .sel      (sel_now),
      .fix_tick (fix_tick),
      .ext_tick (ext_tick),
      .tick     (src_tick)
   );

   tcp_prescaler #(.PS_W(PS_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (src_tick),
      .div_sel (div_sel),
      .fire    (count_en)
   );
endmodule

// File: rtl/tcp_checker.sv
`timescale 1ns/1ps
module tcp_checker #(
   parameter int PS_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      src_sel,
   input logic [PS_W-1:0] div_sel,
   input logic            count_en
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == 2'b00) |-> !count_en);  // R1

   AST_BUS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && src_sel == 2'b01 && div_sel == '0 && $stable(src_sel) && $stable(div_sel))
      |-> count_en);  // R2

   AST_CHANGE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !($stable(src_sel) && $stable(div_sel))) |-> !count_en);  // R4

   AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && count_en && div_sel != '0) |=> !count_en);  // R3

   AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && src_sel == 2'b11 && count_en) |=> !count_en);  // R5
endmodule

bind tmr_clk_prescale tcp_checker #(.PS_W(PS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_sel  (src_sel),
   .div_sel  (div_sel),
   .count_en (count_en)
);

// File: tb/tmr_clk_prescale_test.sv
`timescale 1ns/1ps
module tmr_clk_prescale_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_sel = 2'b01;
   logic [2:0] div_sel = 3'd0;
   logic       fix_clk = 1'b0;
   logic       ext_clk = 1'b0;
   logic       count_en;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   tmr_clk_prescale uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_sel  (src_sel),
      .div_sel  (div_sel),
      .fix_clk  (fix_clk),
      .ext_clk  (ext_clk),
      .count_en (count_en)
   );

   // {source, divide code, expected pulses in 256 cycles}
   localparam int NVEC = 11;
   localparam logic [13:0] VEC [NVEC] = '{
      {2'b01, 3'd0, 9'd256}, {2'b01, 3'd1, 9'd128}, {2'b01, 3'd2, 9'd64},
      {2'b01, 3'd3, 9'd32},  {2'b01, 3'd4, 9'd16},  {2'b01, 3'd5, 9'd8},
      {2'b01, 3'd6, 9'd4},   {2'b01, 3'd7, 9'd2},   {2'b00, 3'd0, 9'd0},
      {2'b01, 3'd0, 9'd256}, {2'b00, 3'd5, 9'd0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle(input logic [1:0] s, input logic [2:0] p);
      @(negedge clk);
      src_sel = s;
      div_sel = p;
      repeat (4) @(negedge clk);
   endtask

   task automatic wave(input int hi, input int lo, input int periods,
                       input bit dext, input bit dfix, output int n);
      n = 0;
      for (int p = 0; p < periods; p++) begin
         for (int k = 0; k < hi + lo; k++) begin
            @(negedge clk); #1;
            if (count_en) n++;
            if (dext) ext_clk = (k < hi);
            if (dfix) fix_clk = (k < hi);
         end
      end
      for (int t = 0; t < 6; t++) begin
         @(negedge clk); #1;
         if (count_en) n++;
         ext_clk = 1'b0;
         fix_clk = 1'b0;
      end
   endtask

   initial begin
      #1_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n;
      int first;
      // R9: reset holds the strobe low, then the prescaler starts from zero
      repeat (3) @(negedge clk);
      #1;
      check(count_en == 1'b0, "R9 in reset", count_en, 0);
      div_sel = 3'd3;
      @(negedge clk);
      rst_n = 1'b1;
      first = 0;
      for (int c = 1; c <= 16; c++) begin
         @(negedge clk); #1;
         if (count_en && first == 0) first = c;
      end
      check(first == 8, "R9 first pulse", first, 8);

      // R1 R2 R3 R4: vector table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] s;
         logic [2:0] p;
         int exp_n;
         int exp_first;
         s = VEC[i][13:12];
         p = VEC[i][11:9];
         exp_n = int'(VEC[i][8:0]);
         exp_first = (s == 2'b00) ? 0 : (1 << p);
         @(negedge clk);
         src_sel = s;
         div_sel = p;
         #1;
         check(count_en == 1'b0, "R4 change cycle", count_en, 0);
         n = 0;
         first = 0;
         for (int c = 1; c <= 256; c++) begin
            @(negedge clk); #1;
            if (count_en) begin
               n++;
               if (first == 0) first = c;
            end
         end
         if (s == 2'b00) check(n == exp_n, "R1 count", n, exp_n);
         else if (p == 3'd0) check(n == exp_n, "R2 count", n, exp_n);
         else check(n == exp_n, "R3 count", n, exp_n);
         check(first == exp_first, "R4 first pulse", first, exp_first);
      end

      // R5 R8: external rising edges at divide-by-1
      settle(2'b11, 3'd0);
      wave(4, 4, 16, 1'b1, 1'b0, n);
      check(n == 16, "R5 ext edges", n, 16);

      // R8: latency from pin edge to strobe
      @(negedge clk);
      ext_clk = 1'b1;
      first = 0;
      for (int c = 1; c <= 6; c++) begin
         @(negedge clk); #1;
         if (count_en && first == 0) first = c;
      end
      check(first == 2, "R8 latency", first, 2);
      @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);

      // R5: quarter-rate pin
      wave(2, 2, 16, 1'b1, 1'b0, n);
      check(n == 16, "R5 quarter rate", n, 16);

      // R3: divide applies after selection of the external source
      settle(2'b11, 3'd2);
      wave(4, 4, 16, 1'b1, 1'b0, n);
      check(n == 4, "R3 ext divide", n, 4);

      // R6 R7: fixed source counts while the external pin also toggles
      settle(2'b10, 3'd0);
      wave(5, 5, 12, 1'b1, 1'b1, n);
      check(n == 12, "R6 fixed edges", n, 12);

      // R7: external selected, only the fixed input toggles
      settle(2'b11, 3'd0);
      wave(5, 5, 10, 1'b0, 1'b1, n);
      check(n == 0, "R7 unselected input", n, 0);

      // R1: source none while both inputs toggle
      settle(2'b00, 3'd0);
      wave(4, 4, 10, 1'b1, 1'b1, n);
      check(n == 0, "R1 none source", n, 0);

      // R9: reset in mid-run forces the strobe low at once
      settle(2'b01, 3'd0);
      #1;
      check(count_en == 1'b1, "R2 running", count_en, 1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(count_en == 1'b0, "R9 mid-run reset", count_en, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule